// File: doc/BRIEF.md
# Packed Lane Compare, Min/Max and Absolute Unit

This block is a purely combinational SIMD datapath slice. It treats a 32-bit word as either four 8-bit lanes or two 16-bit lanes. In each lane it performs equality, less-than or less-or-equal comparisons, a minimum, a maximum or a saturating absolute value. The unit has no width or signedness control input. Both come from the register indices of the operands. Each index range belongs to a bank with a fixed lane width and a fixed signedness, so the same operation select gives signed or unsigned behaviour depending on where the operands live.

The issue stage sends the operation select, a mode field, the destination index and both source indices with their 32-bit values. In the same cycle it gets back the packed result and an illegal flag. When an operation is illegal, the result word is forced to zero, so a writeback stage can discard it safely.

Top module: `pcmp_unit`

## Requirements
- R1: Indices 2..7 select signed 8-bit lanes, 8..15 unsigned 8-bit lanes, 16..23 signed 16-bit lanes and 24..29 unsigned 16-bit lanes. Lane k occupies bits [k*W +: W].
- R2: With op_sel 0 (equal), each result lane is all ones when the two source lanes are equal and all zeros otherwise.
- R3: With op_sel 1 (less-than), each lane is all ones when A < B under the bank's signedness. The condition is formed as neither greater-than nor equal.
- R4: With op_sel 2 (less-or-equal), each lane is all ones when A is not greater than B under the bank's signedness.
- R5: With op_sel 3, each lane holds the smaller of the two source lanes under the bank's signedness.
- R6: With op_sel 4, each lane holds the larger of the two source lanes under the bank's signedness.
- R7: With op_sel 5 and mode 01 (absolute value), a signed-bank lane holds |A|. The most negative value (0x80 or 0x8000) saturates to the most positive value. An unsigned-bank lane passes A through unchanged.
- R8: The absolute value ignores source B. Its index (including 0, 1, 30 and 31) and its value have no effect on the result or on the illegal flag.
- R9: The illegal flag is raised and the result is zero if any index that is used is 0, 1, 30 or 31, or if the used indices are in different banks. For op_sel 0..4 the used indices are destination, A and B. For the absolute value they are destination and A.
- R10: The illegal flag is raised and the result is zero in these cases: op_sel 6 or 7, op_sel 0..4 with a mode other than 00, or op_sel 5 with a mode other than 01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation: 0 eq, 1 lt, 2 le, 3 min, 4 max, 5 abs |
| mode | input | 2 | Mode field; 00 plain, 01 saturating (abs only) |
| dst_idx | input | 5 | Destination register index |
| srca_idx | input | 5 | Source A register index |
| srca_val | input | 32 | Source A packed value |
| srcb_idx | input | 5 | Source B register index |
| srcb_val | input | 32 | Source B packed value |
| result | output | 32 | Packed lane result |
| illegal | output | 1 | Operation/bank combination rejected |

## Verification
The hardest conditions to reach are the lane-boundary values: 0x80/0x7F and 0x8000/0x7FFF paired against each other. Only there do signed and unsigned ordering disagree and the absolute value saturate. Random stimulus over 32-bit words reaches them rarely. Directed words therefore place these extremes in every lane position, and each word is sent through a signed-bank index and through an unsigned-bank index. Random traffic then picks all three indices from one bank most of the time, so that legal operations are not swamped by bank-mismatch rejects.

// File: rtl/pcmp_pkg.sv
// Shared constants and types of the packed compare unit.
// Assumes 5-bit register indices; bank boundaries are architectural.
package pcmp_pkg;
    localparam logic [2:0] OP_EQ  = 3'd0;
    localparam logic [2:0] OP_LT  = 3'd1;
    localparam logic [2:0] OP_LE  = 3'd2;
    localparam logic [2:0] OP_MIN = 3'd3;
    localparam logic [2:0] OP_MAX = 3'd4;
    localparam logic [2:0] OP_ABS = 3'd5;

    localparam logic [1:0] MODE_PLAIN = 2'b00;
    localparam logic [1:0] MODE_SAT   = 2'b01;

    // Bank boundaries (inclusive)
    localparam int S8_LO  = 2;
    localparam int U8_LO  = 8;
    localparam int S16_LO = 16;
    localparam int U16_LO = 24;
    localparam int U16_HI = 29;

    typedef struct packed {
        logic valid;  // index lies inside a data bank
        logic wide;   // 16-bit lanes
        logic sgn;    // signed lanes
    } bank_t;
endpackage

// File: rtl/pcmp_bank_decode.sv
// Maps a register index onto its bank attributes (valid, width, sign).
// Assumes the fixed bank boundaries of pcmp_pkg.
module pcmp_bank_decode
    import pcmp_pkg::*;
(
    input  logic [4:0] idx,
    output bank_t      info
);
    // Range compare of the index against the four bank windows
    always_comb begin
        info = '0;
        if (int'(idx) >= S8_LO && int'(idx) < U8_LO)
            info = '{valid: 1'b1, wide: 1'b0, sgn: 1'b1};
        else if (int'(idx) >= U8_LO && int'(idx) < S16_LO)
            info = '{valid: 1'b1, wide: 1'b0, sgn: 1'b0};
        else if (int'(idx) >= S16_LO && int'(idx) < U16_LO)
            info = '{valid: 1'b1, wide: 1'b1, sgn: 1'b1};
        else if (int'(idx) >= U16_LO && int'(idx) <= U16_HI)
            info = '{valid: 1'b1, wide: 1'b1, sgn: 1'b0};
    end
endmodule

// File: rtl/pcmp_legal.sv
// Decides whether an operation may issue and which lane format it uses.
// Assumes the absolute value takes no part of source B.
module pcmp_legal
    import pcmp_pkg::*;
(
    input  logic [2:0] op_sel,
    input  logic [1:0] mode,
    input  bank_t      dst_bank,
    input  bank_t      a_bank,
    input  bank_t      b_bank,
    output logic       ok,
    output logic       wide,
    output logic       sgn
);
    logic two_src;
    logic mode_ok;
    logic banks_ok;

    // Operation class and its required mode
    always_comb begin
        two_src = (op_sel <= OP_MAX);
        if (two_src)
            mode_ok = (mode == MODE_PLAIN);
        else if (op_sel == OP_ABS)
            mode_ok = (mode == MODE_SAT);
        else
            mode_ok = 1'b0;
    end

    // Bank agreement among the indices the operation uses
    always_comb begin
        banks_ok = a_bank.valid && (dst_bank == a_bank);
        if (two_src)
            banks_ok = banks_ok && (b_bank == a_bank);
    end

    // Final verdict and lane format taken from source A
    always_comb begin
        ok   = mode_ok && banks_ok;
        wide = a_bank.wide;
        sgn  = a_bank.sgn;
    end
endmodule

// File: rtl/pcmp_lane.sv
// One lane of W bits: compare, min, max or saturating absolute value.
// Assumes op_sel has been checked upstream; unknown codes yield zero.
module pcmp_lane
    import pcmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sgn,
    input  logic [2:0]   op_sel,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = ~MOST_NEG;

    logic         gt;
    logic         eq;
    logic         lt;
    logic         le;
    logic [W-1:0] abs_v;

    // Ordering flags; less-than built from inverted greater-than
    always_comb begin
        eq = (a == b);
        gt = sgn ? ($signed(a) > $signed(b)) : (a > b);
        le = ~gt;
        lt = ~(gt | eq);
    end

    // Saturating magnitude of A
    always_comb begin
        if (!sgn)
            abs_v = a;
        else if (a == MOST_NEG)
            abs_v = MOST_POS;
        else if (a[W-1])
            abs_v = ~a + 1'b1;
        else
            abs_v = a;
    end

    // Result selection per operation
    always_comb begin
        case (op_sel)
            OP_EQ:   res = {W{eq}};
            OP_LT:   res = {W{lt}};
            OP_LE:   res = {W{le}};
            OP_MIN:  res = le ? a : b;
            OP_MAX:  res = gt ? a : b;
            OP_ABS:  res = abs_v;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/pcmp_unit.sv
// Packed compare / min / max / absolute unit, combinational.
// Lane width and signedness come from the banks of the register indices;
// an illegal combination zeroes the result.
module pcmp_unit
    import pcmp_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16
) (
    input  logic [2:0]        op_sel,
    input  logic [1:0]        mode,
    input  logic [4:0]        dst_idx,
    input  logic [4:0]        srca_idx,
    input  logic [WORD_W-1:0] srca_val,
    input  logic [4:0]        srcb_idx,
    input  logic [WORD_W-1:0] srcb_val,
    output logic [WORD_W-1:0] result,
    output logic              illegal
);
    localparam int N_NARROW = WORD_W / NARROW_W;
    localparam int N_WIDE   = WORD_W / WIDE_W;

    bank_t              dst_bank;
    bank_t              a_bank;
    bank_t              b_bank;
    logic               ok;
    logic               wide;
    logic               sgn;
    logic [WORD_W-1:0]  narrow_res;
    logic [WORD_W-1:0]  wide_res;

    pcmp_bank_decode i_dec_dst (.idx(dst_idx),  .info(dst_bank));
    pcmp_bank_decode i_dec_a   (.idx(srca_idx), .info(a_bank));
    pcmp_bank_decode i_dec_b   (.idx(srcb_idx), .info(b_bank));

    pcmp_legal i_legal (
        .op_sel   (op_sel),
        .mode     (mode),
        .dst_bank (dst_bank),
        .a_bank   (a_bank),
        .b_bank   (b_bank),
        .ok       (ok),
        .wide     (wide),
        .sgn      (sgn)
    );

    genvar gn;
    generate
        for (gn = 0; gn < N_NARROW; gn++) begin : g_narrow
            pcmp_lane #(.W(NARROW_W)) i_lane (
                .a      (srca_val[gn*NARROW_W +: NARROW_W]),
                .b      (srcb_val[gn*NARROW_W +: NARROW_W]),
                .sgn    (sgn),
                .op_sel (op_sel),
                .res    (narrow_res[gn*NARROW_W +: NARROW_W])
            );
        end
    endgenerate

    genvar gw;
    generate
        for (gw = 0; gw < N_WIDE; gw++) begin : g_wide
            pcmp_lane #(.W(WIDE_W)) i_lane (
                .a      (srca_val[gw*WIDE_W +: WIDE_W]),
                .b      (srcb_val[gw*WIDE_W +: WIDE_W]),
                .sgn    (sgn),
                .op_sel (op_sel),
                .res    (wide_res[gw*WIDE_W +: WIDE_W])
            );
        end
    endgenerate

    // Lane-format selection and zeroing of rejected operations
    always_comb begin
        illegal = ~ok;
        if (!ok)
            result = '0;
        else if (wide)
            result = wide_res;
        else
            result = narrow_res;
    end
endmodule

// File: rtl/pcmp_unit_chk.sv
// Port-level checks on pcmp_unit, attached by bind.
// Assumes the default 32-bit word with 8/16-bit lanes.
module pcmp_unit_chk (
    input logic [2:0]  op_sel,
    input logic [1:0]  mode,
    input logic [4:0]  dst_idx,
    input logic [4:0]  srca_idx,
    input logic [31:0] srca_val,
    input logic [4:0]  srcb_idx,
    input logic [31:0] srcb_val,
    input logic [31:0] result,
    input logic        illegal
);
    function automatic logic in_bank(input logic [4:0] i);
        return (i >= 5'd2) && (i <= 5'd29);
    endfunction

    logic known;

    // Checks on every input/output change once values are defined
    always_comb begin
        known = !$isunknown({op_sel, mode, dst_idx, srca_idx, srca_val,
                             srcb_idx, srcb_val, result, illegal});
        if (known) begin
            // R9
            illegal_zero_chk: assert (!illegal || result == 32'd0);
            // R10
            opcode_reject_chk: assert (op_sel < 3'd6 || illegal);
            // R9
            reserved_idx_chk: assert ((in_bank(dst_idx) && in_bank(srca_idx)) || illegal);
            if (!illegal && op_sel == 3'd0) begin
                for (int k = 0; k < 4; k++) begin
                    // R2
                    eq_mask_chk: assert (result[k*8 +: 8] == 8'h00 || result[k*8 +: 8] == 8'hFF);
                end
            end
            if (!illegal && op_sel == 3'd3 && srca_idx < 5'd16) begin
                for (int k = 0; k < 4; k++) begin
                    // R5
                    min_pick_chk: assert (result[k*8 +: 8] == srca_val[k*8 +: 8] ||
                                          result[k*8 +: 8] == srcb_val[k*8 +: 8]);
                end
            end
            if (!illegal && op_sel == 3'd5 && srca_idx <= 5'd7) begin
                for (int k = 0; k < 4; k++) begin
                    // R7
                    abs_sign8_chk: assert (!result[k*8 + 7]);
                end
            end
            if (!illegal && op_sel == 3'd5 && srca_idx >= 5'd16 && srca_idx <= 5'd23) begin
                // R7
                abs_sign16_chk: assert (!result[15] && !result[31]);
            end
        end
    end
endmodule

bind pcmp_unit pcmp_unit_chk i_chk (.*);

// File: tb/test_pcmp_unit.sv
// Bench for pcmp_unit: behavioural reference compared every clock.
module test_pcmp_unit;
    logic        clk = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [1:0]  mode = '0;
    logic [4:0]  dst_idx = '0;
    logic [4:0]  srca_idx = '0;
    logic [31:0] srca_val = '0;
    logic [4:0]  srcb_idx = '0;
    logic [31:0] srcb_val = '0;
    logic [31:0] result;
    logic        illegal;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    pcmp_unit i_pcmp_unit (.*);

    always #10 clk = ~clk;

    // 0 none, 1 s8, 2 u8, 3 s16, 4 u16
    function automatic int bank_of(input int i);
        if (i >= 2 && i <= 7)   return 1;
        if (i >= 8 && i <= 15)  return 2;
        if (i >= 16 && i <= 23) return 3;
        if (i >= 24 && i <= 29) return 4;
        return 0;
    endfunction

    task automatic model(output logic [31:0] r, output logic il);
        int ba, bd, bb, w, sg, full, x, y, o;
        bit ok;
        ba = bank_of(int'(srca_idx));
        bd = bank_of(int'(dst_idx));
        bb = bank_of(int'(srcb_idx));
        ok = (ba != 0) && (ba == bd);
        if (op_sel == 3'd5) ok = ok && (mode == 2'b01);
        else ok = ok && (op_sel <= 3'd4) && (mode == 2'b00) && (bb == ba);
        r  = 32'd0;
        il = !ok;
        if (!ok) return;
        w    = (ba <= 2) ? 8 : 16;
        sg   = (ba == 1 || ba == 3) ? 1 : 0;
        full = (1 << w);
        for (int l = 0; l < 32 / w; l++) begin
            x = int'((srca_val >> (l * w)) & 32'(full - 1));
            y = int'((srcb_val >> (l * w)) & 32'(full - 1));
            if (sg != 0 && x >= full / 2) x -= full;
            if (sg != 0 && y >= full / 2) y -= full;
            case (op_sel)
                3'd0: o = (x == y) ? -1 : 0;
                3'd1: o = (x < y) ? -1 : 0;
                3'd2: o = (x <= y) ? -1 : 0;
                3'd3: o = (x < y) ? x : y;
                3'd4: o = (x > y) ? x : y;
                default: begin
                    o = (x < 0) ? -x : x;
                    if (o > full / 2 - 1 && sg != 0) o = full / 2 - 1;
                end
            endcase
            r = r | ((32'(o) & 32'(full - 1)) << (l * w));
        end
    endtask

    task automatic apply(input string tag, input logic [2:0] op, input logic [1:0] md,
                         input int d, input int ia, input logic [31:0] va,
                         input int ib, input logic [31:0] vb);
        logic [31:0] er;
        logic        ei;
        @(posedge clk);
        op_sel = op; mode = md; dst_idx = 5'(d);
        srca_idx = 5'(ia); srca_val = va; srcb_idx = 5'(ib); srcb_val = vb;
        @(negedge clk);
        model(er, ei);
        n_cmp++;
        if (result !== er || illegal !== ei) begin
            n_bad++;
            $display("FAIL %s op=%0d d=%0d a=%0d b=%0d: got %h/%b expected %h/%b",
                     tag, op, d, ia, ib, result, illegal, er, ei);
        end
    endtask

    function automatic int same_bank(input int i);
        int b;
        b = bank_of(i);
        case (b)
            1: return int'($urandom_range(7, 2));
            2: return int'($urandom_range(15, 8));
            3: return int'($urandom_range(23, 16));
            default: return int'($urandom_range(29, 24));
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // Idle state: all-zero inputs are rejected (R9)
        apply("R9 idle", 3'd0, 2'b00, 0, 0, 32'h0, 0, 32'h0);
        // R1 R2: equality on each bank
        apply("R2 eq s8", 3'd0, 2'b00, 2, 3, 32'h11223344, 4, 32'h11FF3300);
        apply("R2 eq u16", 3'd0, 2'b00, 24, 25, 32'h8000ABCD, 29, 32'h8000ABCE);
        // R3 less-than: signed vs unsigned on extremes
        apply("R3 lt s8", 3'd1, 2'b00, 2, 5, 32'h807F00FF, 7, 32'h7F8001FF);
        apply("R3 lt u8", 3'd1, 2'b00, 8, 9, 32'h807F00FF, 15, 32'h7F8001FF);
        apply("R3 lt s16", 3'd1, 2'b00, 16, 17, 32'h80007FFF, 23, 32'h7FFF8000);
        apply("R3 lt u16", 3'd1, 2'b00, 24, 26, 32'h80007FFF, 28, 32'h7FFF8000);
        // R4 less-or-equal including equal lanes
        apply("R4 le s8", 3'd2, 2'b00, 6, 2, 32'h80FF0101, 3, 32'h80000100);
        apply("R4 le u16", 3'd2, 2'b00, 27, 24, 32'hFFFF0001, 25, 32'hFFFE0001);
        // R5 R6 min/max under both signedness
        apply("R5 min s8", 3'd3, 2'b00, 4, 4, 32'h80017FFE, 4, 32'h7F0280FF);
        apply("R5 min u8", 3'd3, 2'b00, 10, 11, 32'h80017FFE, 12, 32'h7F0280FF);
        apply("R6 max s16", 3'd4, 2'b00, 20, 21, 32'h8000FFFF, 22, 32'h7FFF0000);
        apply("R6 max u16", 3'd4, 2'b00, 29, 29, 32'h8000FFFF, 29, 32'h7FFF0000);
        // R7 absolute value with saturation
        apply("R7 abs s8", 3'd5, 2'b01, 3, 4, 32'h80FF7F00, 5, 32'h0);
        apply("R7 abs s16", 3'd5, 2'b01, 16, 18, 32'h8000FFFE, 19, 32'h0);
        apply("R7 abs u8", 3'd5, 2'b01, 9, 10, 32'h80FF7F00, 11, 32'h0);
        // R8 source B ignored by absolute value
        apply("R8 abs b0", 3'd5, 2'b01, 16, 17, 32'h8001C000, 0, 32'hDEADBEEF);
        apply("R8 abs b31", 3'd5, 2'b01, 16, 17, 32'h8001C000, 31, 32'h12345678);
        apply("R8 abs bx", 3'd5, 2'b01, 2, 2, 32'h81FE0280, 24, 32'hFFFFFFFF);
        // R9 reserved indices and bank mismatch
        apply("R9 idx30", 3'd0, 2'b00, 30, 24, 32'h1, 24, 32'h1);
        apply("R9 idx1", 3'd3, 2'b00, 2, 1, 32'h1, 2, 32'h1);
        apply("R9 mix", 3'd4, 2'b00, 2, 3, 32'h5, 8, 32'h5);
        apply("R9 mixd", 3'd5, 2'b01, 16, 24, 32'h8000, 24, 32'h0);
        // R10 opcode and mode rejects
        apply("R10 op6", 3'd6, 2'b00, 2, 2, 32'h1, 2, 32'h1);
        apply("R10 op7", 3'd7, 2'b01, 2, 2, 32'h1, 2, 32'h1);
        apply("R10 eqmode", 3'd0, 2'b01, 2, 2, 32'h1, 2, 32'h1);
        apply("R10 absmode", 3'd5, 2'b00, 2, 2, 32'h80, 2, 32'h1);
        // Random traffic, mostly same-bank operands (R1..R6)
        for (int n = 0; n < 3000; n++) begin
            int ia, d, ib;
            logic [2:0] op;
            ia = int'($urandom_range(31, 0));
            d  = ($urandom_range(9, 0) != 0 && bank_of(ia) != 0) ? same_bank(ia) : int'($urandom_range(31, 0));
            ib = ($urandom_range(9, 0) != 0 && bank_of(ia) != 0) ? same_bank(ia) : int'($urandom_range(31, 0));
            op = 3'($urandom_range(7, 0));
            apply("R1 random", op, (op == 3'd5) ? 2'b01 : 2'b00, d, ia,
                  $urandom(), ib, ($urandom_range(3, 0) == 0) ? 32'h80008000 : $urandom());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule